// File: doc/BRIEF.md
# ATA Task-File Register Front-End

This block is the host-facing register set of a single parallel disk device on a small I/O port. A host writes the sector count, the three address bytes and the device-select byte at fixed offsets. It then writes a command byte to the shared status/command offset. The block decodes that byte. It raises BSY while work is outstanding, DRQ while identification data is ready, and ERR for a command it does not know. It drives one interrupt line, and a read of status drops that line.

Four commands are handled. IDENTIFY streams 256 sixteen-bit words through the data port, one per read. The words are built from parameters: a serial string, a firmware version string and a write-cache-enabled flag. Each string carries its first character in the high byte of each word. FLUSH CACHE sends a one-cycle request to a backend and stays busy until a done input arrives. READ DMA and WRITE DMA send a one-cycle request to an external DMA engine. The request carries the 24-bit address, the sector count and a direction flag. The block then stays busy until the engine strobes completion.

Top module: `ata_taskfile_front`

## Requirements
- R1: After reset, a status read (offset 7) returns 0x40 (DRDY only), irq is low, and neither dmaReqValid nor flushReq is asserted.
- R2: Bytes written at offsets 2 (count), 3, 4 and 5 (address low, middle, high) and 6 (device select) read back unchanged in the low byte of ioRdData. A device-select value with bit 4 clear (device 0) reads back with bit 4 clear.
- R3: Command 0xEC raises irq and enters the data phase. Before each of exactly 256 data-port reads (offset 0), status reads 0x48 (DRDY and DRQ). After the last read, status returns to 0x40. A data-port read outside the data phase returns 0.
- R4: In the identification words, words 10 to 19 hold the 20-byte serial string and words 23 to 26 hold the 8-byte version string. Each word has the earlier character in bits 15:8. Word 85 is 0x0020, with bit 5 reporting that the write cache is enabled. All other words are 0.
- R5: Command 0xE7 pulses flushReq for exactly one cycle, and status reads 0xC0 (BSY and DRDY) until flushDone. The clock edge that samples flushDone returns status to 0x40 and raises irq.
- R6: Command 0xC8 or 0xCA pulses dmaReqValid for one cycle. With it, dmaLba = {offset 5, offset 4, offset 3} and dmaCount = offset 2. dmaToHost is 1 for 0xC8 and 0 for 0xCA. Status reads 0xC0 until dmaDone, then returns to 0x40 with irq raised.
- R7: A status read clears irq at the clock edge that ends the read. If a completion event falls in that same cycle, irq stays set, and the read returns the status from before the completion.
- R8: Any other command byte leaves the block idle with status 0x41 (DRDY and ERR) and raises irq. The next recognised command clears ERR.
- R9: A command write while the block is busy or in the data phase is ignored. Status and the outstanding operation are unchanged.
- R10: BSY and DRQ are never set together in a status read, and BSY is never set without DRDY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 3 | Register offset |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access; side effects at the edge ending it |
| ioWrData | input | 8 | Write byte |
| ioRdData | output | 16 | Read data, combinational from the addressed register |
| irq | output | 1 | Interrupt request |
| dmaReqValid | output | 1 | One-cycle DMA request |
| dmaToHost | output | 1 | DMA direction, 1 = device to memory |
| dmaLba | output | 24 | DMA start address |
| dmaCount | output | 8 | DMA sector count |
| dmaDone | input | 1 | DMA engine completion strobe |
| flushReq | output | 1 | One-cycle flush request to the backend |
| flushDone | input | 1 | Backend flush completion strobe |

## Verification
A host status read that clears the interrupt and a backend completion that sets it can land in the same cycle. The bench provokes this by asserting flushDone in the cycle where it reads status during an outstanding flush. It expects the read to still show 0xC0 and irq to remain high after that edge, and a second status read to show 0x40 and clear irq. The checks also cover command writes during busy and data phases, which must not disturb the status or the pending request.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [2:0] ADDR_DATA    = 3'd0;
  localparam logic [2:0] ADDR_COUNT   = 3'd2;
  localparam logic [2:0] ADDR_LBA0    = 3'd3;
  localparam logic [2:0] ADDR_LBA1    = 3'd4;
  localparam logic [2:0] ADDR_LBA2    = 3'd5;
  localparam logic [2:0] ADDR_DEVSEL  = 3'd6;
  localparam logic [2:0] ADDR_STATCMD = 3'd7;

  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;

  localparam logic [7:0] OP_RD_DMA = 8'hC8;
  localparam logic [7:0] OP_WR_DMA = 8'hCA;
  localparam logic [7:0] OP_FLUSH  = 8'hE7;
  localparam logic [7:0] OP_IDENT  = 8'hEC;

  typedef enum logic [1:0] {PH_IDLE, PH_PIO, PH_FLUSH, PH_DMA} phase_t;

  typedef struct packed {
    logic idxClear;
    logic idxStep;
    logic pioActive;
  } dpStrobes_t;
endpackage

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int WORDS         = 256,
  parameter int SERIAL_BYTES  = 20,
  parameter int VERSION_BYTES = 8,
  parameter int SER_FIRST     = 10,
  parameter int VER_FIRST     = 23,
  parameter int CACHE_WORD    = 85,
  parameter logic [SERIAL_BYTES*8-1:0]  SERIAL_TEXT  = "SN-ABCD-0042        ",
  parameter logic [VERSION_BYTES*8-1:0] VERSION_TEXT = "FW1.23  "
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  ioAddr,
  input  logic        ioWr,
  input  logic [7:0]  ioWrData,
  input  dpStrobes_t  strobes,
  input  logic [7:0]  statusByte,
  output logic [15:0] ioRdData,
  output logic        lastWord,
  output logic [23:0] lba,
  output logic [7:0]  count
);
  localparam int IDX_W    = $clog2(WORDS);
  localparam int SER_LAST = SER_FIRST + SERIAL_BYTES / 2 - 1;
  localparam int VER_LAST = VER_FIRST + VERSION_BYTES / 2 - 1;

  logic [7:0] lbaLow, lbaMid, lbaHigh, devSel;
  logic [IDX_W-1:0] wordIdx;
  logic [15:0] identWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0; lbaLow <= '0; lbaMid <= '0; lbaHigh <= '0; devSel <= '0;
    end else if (ioWr) begin
      case (ioAddr)
        ADDR_COUNT:  count   <= ioWrData;
        ADDR_LBA0:   lbaLow  <= ioWrData;
        ADDR_LBA1:   lbaMid  <= ioWrData;
        ADDR_LBA2:   lbaHigh <= ioWrData;
        ADDR_DEVSEL: devSel  <= ioWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.idxClear) wordIdx <= '0;
    else if (strobes.idxStep)      wordIdx <= wordIdx + 1'b1;
  end

  assign lastWord = (int'(wordIdx) == WORDS - 1);
  assign lba      = {lbaHigh, lbaMid, lbaLow};

  // Two characters per word, earlier character in the high byte.
  always_comb begin
    int w;
    w = int'(wordIdx);
    identWord = '0;
    if (w >= SER_FIRST && w <= SER_LAST)
      identWord = 16'(SERIAL_TEXT >> (SERIAL_BYTES*8 - 16*(w - SER_FIRST + 1)));
    else if (w >= VER_FIRST && w <= VER_LAST)
      identWord = 16'(VERSION_TEXT >> (VERSION_BYTES*8 - 16*(w - VER_FIRST + 1)));
    else if (w == CACHE_WORD)
      identWord = 16'h0020;
  end

  always_comb begin
    case (ioAddr)
      ADDR_DATA:    ioRdData = strobes.pioActive ? identWord : 16'h0000;
      ADDR_COUNT:   ioRdData = {8'h00, count};
      ADDR_LBA0:    ioRdData = {8'h00, lbaLow};
      ADDR_LBA1:    ioRdData = {8'h00, lbaMid};
      ADDR_LBA2:    ioRdData = {8'h00, lbaHigh};
      ADDR_DEVSEL:  ioRdData = {8'h00, devSel};
      ADDR_STATCMD: ioRdData = {8'h00, statusByte};
      default:      ioRdData = 16'h0000;
    endcase
  end
endmodule

// File: rtl/ata_tf_control.sv
module ata_tf_control
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ioAddr,
  input  logic       ioWr,
  input  logic       ioRd,
  input  logic [7:0] ioWrData,
  input  logic       lastWord,
  input  logic       dmaDone,
  input  logic       flushDone,
  output dpStrobes_t strobes,
  output logic [7:0] statusByte,
  output logic       irq,
  output logic       dmaReqValid,
  output logic       dmaToHost,
  output logic       flushReq
);
  phase_t phase;
  logic errFlag;
  logic cmdAccept, statRd, dataRd, isIdent, isFlush, isDma, setIrq;

  assign cmdAccept = ioWr && ioAddr == ADDR_STATCMD && phase == PH_IDLE;
  assign statRd    = ioRd && ioAddr == ADDR_STATCMD;
  assign dataRd    = ioRd && ioAddr == ADDR_DATA && phase == PH_PIO;
  assign isIdent   = ioWrData == OP_IDENT;
  assign isFlush   = ioWrData == OP_FLUSH;
  assign isDma     = ioWrData == OP_RD_DMA || ioWrData == OP_WR_DMA;

  // Identify and unknown commands interrupt at once; flush and DMA on completion.
  assign setIrq = (cmdAccept && !isFlush && !isDma)
               || (phase == PH_FLUSH && flushDone)
               || (phase == PH_DMA && dmaDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE; errFlag <= 1'b0; irq <= 1'b0;
      dmaReqValid <= 1'b0; dmaToHost <= 1'b0; flushReq <= 1'b0;
    end else begin
      dmaReqValid <= 1'b0;
      flushReq    <= 1'b0;
      if (setIrq)      irq <= 1'b1;
      else if (statRd) irq <= 1'b0;
      case (phase)
        PH_IDLE: if (cmdAccept) begin
          errFlag <= !(isIdent || isFlush || isDma);
          if (isIdent) phase <= PH_PIO;
          if (isFlush) begin
            phase <= PH_FLUSH; flushReq <= 1'b1;
          end
          if (isDma) begin
            phase <= PH_DMA; dmaReqValid <= 1'b1;
            dmaToHost <= (ioWrData == OP_RD_DMA);
          end
        end
        PH_PIO:   if (dataRd && lastWord) phase <= PH_IDLE;
        PH_FLUSH: if (flushDone)          phase <= PH_IDLE;
        PH_DMA:   if (dmaDone)            phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_PIO:            statusByte = ST_DRDY | ST_DRQ;
      PH_FLUSH, PH_DMA:  statusByte = ST_BSY | ST_DRDY;
      default:           statusByte = errFlag ? (ST_DRDY | ST_ERR) : ST_DRDY;
    endcase
  end

  assign strobes.idxClear  = cmdAccept && isIdent;
  assign strobes.idxStep   = dataRd;
  assign strobes.pioActive = phase == PH_PIO;
endmodule

// File: rtl/ata_taskfile_front.sv
module ata_taskfile_front
  import ata_tf_pkg::*;
#(
  parameter int WORDS         = 256,
  parameter int SERIAL_BYTES  = 20,
  parameter int VERSION_BYTES = 8,
  parameter logic [SERIAL_BYTES*8-1:0]  SERIAL_TEXT  = "SN-ABCD-0042        ",
  parameter logic [VERSION_BYTES*8-1:0] VERSION_TEXT = "FW1.23  "
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  ioAddr,
  input  logic        ioWr,
  input  logic        ioRd,
  input  logic [7:0]  ioWrData,
  output logic [15:0] ioRdData,
  output logic        irq,
  output logic        dmaReqValid,
  output logic        dmaToHost,
  output logic [23:0] dmaLba,
  output logic [7:0]  dmaCount,
  input  logic        dmaDone,
  output logic        flushReq,
  input  logic        flushDone
);
  dpStrobes_t strobes;
  logic [7:0] statusByte;
  logic lastWord;

  ata_tf_control u_ctl (
    .clk, .rstN, .ioAddr, .ioWr, .ioRd, .ioWrData, .lastWord,
    .dmaDone, .flushDone, .strobes, .statusByte, .irq,
    .dmaReqValid, .dmaToHost, .flushReq
  );

  ata_tf_datapath #(
    .WORDS(WORDS), .SERIAL_BYTES(SERIAL_BYTES), .VERSION_BYTES(VERSION_BYTES),
    .SERIAL_TEXT(SERIAL_TEXT), .VERSION_TEXT(VERSION_TEXT)
  ) u_dp (
    .clk, .rstN, .ioAddr, .ioWr, .ioWrData, .strobes, .statusByte,
    .ioRdData, .lastWord, .lba(dmaLba), .count(dmaCount)
  );
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  ioAddr,
  input logic        ioRd,
  input logic [15:0] ioRdData,
  input logic        irq,
  input logic        dmaReqValid,
  input logic        flushReq
);
  logic statRd;
  assign statRd = ioRd && ioAddr == 3'd7;

  AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> !(ioRdData[7] && ioRdData[3])); // R10
  AST_BSY_WITH_DRDY: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && ioRdData[7]) |-> ioRdData[6]); // R10
  AST_IRQ_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(statRd)); // R7
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !flushReq); // R5
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReqValid |=> !dmaReqValid); // R6
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaReqValid && flushReq)); // R9
endmodule

bind ata_taskfile_front ata_tf_checker u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioRdData(ioRdData),
  .irq(irq), .dmaReqValid(dmaReqValid), .flushReq(flushReq)
);

// File: tb/ata_taskfile_front_test.sv
module ata_taskfile_front_test;
  localparam string SER = "SN-ABCD-0042        ";
  localparam string VER = "FW1.23  ";

  logic clk = 0, rstN = 0;
  logic [2:0] ioAddr = 0;
  logic ioWr = 0, ioRd = 0, dmaDone = 0, flushDone = 0;
  logic [7:0] ioWrData = 0;
  logic [15:0] ioRdData;
  logic irq, dmaReqValid, dmaToHost, flushReq;
  logic [23:0] dmaLba;
  logic [7:0] dmaCount;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ata_taskfile_front #(
    .SERIAL_TEXT("SN-ABCD-0042        "), .VERSION_TEXT("FW1.23  ")
  ) uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v);
    @(negedge clk); ioAddr = a; ioWrData = v; ioWr = 1;
    @(negedge clk); ioWr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); ioAddr = a; ioRd = 1; #2; d = ioRdData;
    @(negedge clk); ioRd = 0;
  endtask

  function automatic logic [15:0] expWord(int i);
    if (i >= 10 && i <= 19) return {SER[2*(i-10)], SER[2*(i-10)+1]};
    if (i >= 23 && i <= 26) return {VER[2*(i-23)], VER[2*(i-23)+1]};
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic testReset();
    logic [15:0] d;
    check("R1 irq", irq, 0);
    check("R1 strobes", {dmaReqValid, flushReq}, 0);
    rd(7, d); check("R1 status", d, 16'h0040);
  endtask

  task automatic testRegs();
    logic [15:0] d;
    wr(2, 8'h03); wr(3, 8'h12); wr(4, 8'h34); wr(5, 8'h56); wr(6, 8'h40);
    rd(2, d); check("R2 count", d, 16'h0003);
    rd(3, d); check("R2 lba low", d, 16'h0012);
    rd(4, d); check("R2 lba mid", d, 16'h0034);
    rd(5, d); check("R2 lba high", d, 16'h0056);
    rd(6, d); check("R2 device0 bit4", d[4], 0);
    check("R2 devsel", d, 16'h0040);
  endtask

  task automatic testUnknown();
    logic [15:0] d;
    wr(7, 8'h5A);
    check("R8 irq", irq, 1);
    rd(7, d); check("R8 status err", d, 16'h0041);
    check("R7 irq cleared by read", irq, 0);
  endtask

  task automatic testIdentify();
    logic [15:0] d, s;
    int bad = 0;
    rd(0, d); check("R3 data outside phase", d, 0);
    wr(7, 8'hEC);
    check("R3 irq on ready", irq, 1);
    for (int i = 0; i < 256; i++) begin
      rd(7, s);
      if (s != 16'h0048) begin bad++; check("R3 status per word", s, 16'h0048); end
      if (i == 3) begin
        wr(7, 8'hE7);
        check("R9 no flush during data phase", flushReq, 0);
      end
      rd(0, d);
      if (d != expWord(i)) begin bad++; check("R4 identify word", d, expWord(i)); end
    end
    check("R3 R4 word stream mismatches", bad, 0);
    check("R3 irq cleared", irq, 0);
    rd(7, s); check("R3 status after last", s, 16'h0040);
    rd(0, d); check("R3 data after last", d, 0);
  endtask

  task automatic testFlush();
    logic [15:0] d;
    wr(7, 8'hE7);
    check("R5 flushReq pulse", flushReq, 1);
    @(negedge clk); check("R5 flushReq one cycle", flushReq, 0);
    rd(7, d); check("R5 busy status", d, 16'h00C0);
    check("R8 err cleared (no irq yet)", irq, 0);
    wr(7, 8'hC8);
    check("R9 no dma during flush", dmaReqValid, 0);
    rd(7, d); check("R9 still busy", d, 16'h00C0);
    @(negedge clk); ioAddr = 7; ioRd = 1; flushDone = 1; #2; d = ioRdData;
    @(negedge clk); ioRd = 0; flushDone = 0;
    check("R7 collision read sees busy", d, 16'h00C0);
    check("R7 set wins over clear", irq, 1);
    rd(7, d); check("R5 R8 done status", d, 16'h0040);
    check("R7 irq cleared", irq, 0);
  endtask

  task automatic testDma();
    logic [15:0] d;
    wr(7, 8'hC8);
    check("R6 req", dmaReqValid, 1);
    check("R6 lba", dmaLba, 24'h563412);
    check("R6 count", dmaCount, 8'h03);
    check("R6 dir read", dmaToHost, 1);
    @(negedge clk); check("R6 req one cycle", dmaReqValid, 0);
    rd(7, d); check("R6 busy", d, 16'h00C0);
    @(negedge clk); dmaDone = 1; @(negedge clk); dmaDone = 0;
    check("R6 irq on done", irq, 1);
    rd(7, d); check("R6 idle", d, 16'h0040);
    wr(3, 8'hAA); wr(7, 8'hCA);
    check("R6 dir write", dmaToHost, 0);
    check("R6 lba2", dmaLba, 24'h5634AA);
    @(negedge clk); dmaDone = 1; @(negedge clk); dmaDone = 0;
    rd(7, d); check("R6 idle2", d, 16'h0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRegs();
    testUnknown();
    testIdentify();
    testFlush();
    testDma();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule